// File: doc/BRIEF.md
# DRAM Initialization Command Sequencer

This block plays a short, software-prepared list of DRAM commands out onto a DRAM command bus when memory is brought up. Software first fills a table of command slots. Each slot holds the command pins, the bank address, an address or mode value, and the pause that must follow the command. Software then writes the slot count and a valid flag, and sets a start bit. The sequencer issues slot 0, waits, issues slot 1, and carries on until the last programmed slot has been sent and its pause has expired. At that point the valid flag drops by itself, so software can poll it to know the bus is free.

The pause of each slot is stored as the required wait minus two cycles, with zero as the smallest value. A stored value of N therefore spaces that command N+2 clock cycles ahead of the next one.

Outside its single issue cycle, the bus carries a deselect: all four command pins are high and the bank and address lines are zero. The clock-enable pin stays low after reset until the first command goes out, and stays high from then on. A separate init-done bit is kept for software to mark the move to normal operation.

Top module: `init_cmd_sequencer`

## Requirements
- R1: Register map, selected by `wr_addr` (6 bits at default parameters).
  - Table words: bit 5 = 0, bits [4:1] = slot, bit 0 = word select.
  - Word 0 of a slot: bits [3:0] = {cs_n, ras_n, cas_n, we_n}, bits [6:4] = bank, bits [9:7] = address bits [13:11].
  - Word 1 of a slot: bits [10:0] = address bits [10:0], bits [31:11] = stored delay.
  - Address 0x20 is the issue register: bit 31 = valid, bits [3:0] = count.
  - Address 0x21 is the control register: bit 0 = start, bit 1 = init-done.
- R2: A slot is issued for exactly one cycle. In that cycle the command pins, `ba` and `addr` equal the slot's fields, and the first issue cycle directly follows the clock edge that accepted the start write.
- R3: Each issue cycle follows the previous one by (stored delay of the previous slot + 2) cycles.
- R4: A run issues slots 0 through min(count, 11) in order, so a count of 11 gives 12 commands, and any count of 12 or more is treated as 11.
- R5: The valid flag stays set for the whole run. It drops in the cycle that lies (stored delay of the last slot + 2) cycles after that slot's issue cycle.
- R6: A start write takes effect only when the valid flag is set and no run is active. Otherwise it issues nothing.
- R7: In every cycle that is not an issue cycle, all four command pins are high and `ba` and `addr` are zero.
- R8: `cke` is low from reset until the first issue cycle. It is high in that cycle and in every cycle after it.
- R9: Table writes have no effect while the valid flag is set. Issue-register writes have no effect while a run is active.
- R10: Bit 1 of every control-register write is stored and shown on `init_done`. It does not change the command bus.
- R11: After reset, `cmd_valid` and `init_done` are low, `cke` is low and the bus carries a deselect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register write address (width is $clog2(SLOTS)+2) |
| wr_data | input | 32 | Register write data |
| cke | output | 1 | DRAM clock enable |
| cs_n | output | 1 | DRAM chip select, active low |
| ras_n | output | 1 | DRAM row strobe, active low |
| cas_n | output | 1 | DRAM column strobe, active low |
| we_n | output | 1 | DRAM write enable, active low |
| ba | output | 3 | DRAM bank address (BA_W) |
| addr | output | 14 | DRAM address (ADDR_W) |
| cmd_valid | output | 1 | Issue valid flag; clears itself when the run ends |
| init_done | output | 1 | Stored init-done bit |

## Verification
The bench builds the block with its defaults: 12 slots, a 3-bit bank and a 14-bit address. With these values the 4-bit count field can hold 12 through 15, so the clamp on the last slot can be reached. They also allow a full twelve-command power-up list with precharge-all on address bit 10. The 21-bit delay field is exercised from a stored zero, which gives back-to-back commands two cycles apart, up to a stored 1000, which checks that a long pause ends on the exact cycle.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_ISSUE = 2'd1,
    SQ_WAIT  = 2'd2
  } sq_state_e;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned FIELD_W   = 11;
  localparam int unsigned PIN_W     = 4;
  localparam int unsigned VALID_POS = 31;
  localparam int unsigned START_POS = 0;
  localparam int unsigned DONE_POS  = 1;

endpackage

// File: rtl/iseq_slot_table.sv
module iseq_slot_table #(
  parameter int SLOTS = 12,
  parameter int IDX_W = 4,
  parameter int CMD_W = 10,
  parameter int PAR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_word,
  input  logic [PAR_W-1:0] wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CMD_W-1:0] rd_cmd,
  output logic [PAR_W-1:0] rd_par
);

  logic [CMD_W-1:0] cmd_q [SLOTS];
  logic [PAR_W-1:0] par_q [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmd_q[s] <= '0;
        par_q[s] <= '0;
      end else if (wr_go && wr_idx == IDX_W'(s)) begin
        if (wr_word) par_q[s] <= wr_data;
        else         cmd_q[s] <= wr_data[CMD_W-1:0];
      end
    end
  end

  assign rd_cmd = cmd_q[rd_idx];
  assign rd_par = par_q[rd_idx];

endmodule

// File: rtl/iseq_ctrl_regs.sv
module iseq_ctrl_regs #(
  parameter int SLOTS = 12,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_we,
  input  logic [IDX_W-1:0] issue_cnt_in,
  input  logic             issue_valid_in,
  input  logic             mem_we,
  input  logic             mem_start_in,
  input  logic             mem_done_in,
  input  logic             seq_busy,
  input  logic             seq_done,
  output logic             cmd_valid,
  output logic             init_done,
  output logic             launch,
  output logic [IDX_W-1:0] last_idx
);

  logic [IDX_W-1:0] count_q;

  // Highest slot index a run may reach, whatever the programmed count.
  function automatic logic [IDX_W-1:0] clamp_last(input logic [IDX_W-1:0] c);
    if ({1'b0, c} > (IDX_W+1)'(SLOTS - 1)) return IDX_W'(SLOTS - 1);
    return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q   <= '0;
      cmd_valid <= 1'b0;
      init_done <= 1'b0;
    end else begin
      if (seq_done) begin
        cmd_valid <= 1'b0;
      end else if (issue_we && !seq_busy) begin
        count_q   <= issue_cnt_in;
        cmd_valid <= issue_valid_in;
      end
      if (mem_we) init_done <= mem_done_in;
    end
  end

  assign launch   = mem_we && mem_start_in && cmd_valid && !seq_busy;
  assign last_idx = clamp_last(count_q);

endmodule

// File: rtl/iseq_engine.sv
module iseq_engine
  import iseq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int DLY_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [IDX_W-1:0] last_idx,
  input  logic [DLY_W-1:0] slot_dly,
  output logic [IDX_W-1:0] idx,
  output logic             issue_stb,
  output logic             seq_busy,
  output logic             seq_done,
  output logic             cke_q
);

  sq_state_e        state;
  logic [DLY_W-1:0] cnt_q;

  // The counter is loaded with the stored delay, so the wait phase lasts
  // stored+1 cycles and the issue-to-issue distance is stored+2.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      idx   <= '0;
      cnt_q <= '0;
      cke_q <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (launch) begin
            idx   <= '0;
            state <= SQ_ISSUE;
          end
        end
        SQ_ISSUE: begin
          cnt_q <= slot_dly;
          cke_q <= 1'b1;
          state <= SQ_WAIT;
        end
        SQ_WAIT: begin
          if (cnt_q == '0) begin
            if (idx == last_idx) begin
              state <= SQ_IDLE;
            end else begin
              idx   <= idx + 1'b1;
              state <= SQ_ISSUE;
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign issue_stb = (state == SQ_ISSUE);
  assign seq_busy  = (state != SQ_IDLE);
  assign seq_done  = (state == SQ_WAIT) && (cnt_q == '0) && (idx == last_idx);

endmodule

// File: rtl/init_cmd_sequencer.sv
module init_cmd_sequencer
  import iseq_pkg::*;
#(
  parameter int SLOTS  = 12,
  parameter int BA_W   = 3,
  parameter int ADDR_W = 14,
  localparam int IDX_W = $clog2(SLOTS),
  localparam int AW    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cmd_valid,
  output logic              init_done
);

  localparam int AHI_W = ADDR_W - FIELD_W;
  localparam int CMD_W = PIN_W + BA_W + AHI_W;
  localparam int DLY_W = WORD_W - FIELD_W;

  logic             is_ctrl, word_sel, in_range, tbl_go, issue_we, mem_we;
  logic [IDX_W-1:0] sel;
  logic [IDX_W-1:0] cur_idx, last_idx;
  logic [CMD_W-1:0] rd_cmd;
  logic [WORD_W-1:0] rd_par;
  logic             launch, issue_stb, seq_busy, seq_done, cke_q;

  function automatic logic [ADDR_W-1:0] compose_addr(input logic [CMD_W-1:0] c,
                                                      input logic [WORD_W-1:0] p);
    return {c[PIN_W+BA_W +: AHI_W], p[FIELD_W-1:0]};
  endfunction

  assign is_ctrl  = wr_addr[AW-1];
  assign sel      = wr_addr[AW-2:1];
  assign word_sel = wr_addr[0];
  assign in_range = {1'b0, sel} < (IDX_W+1)'(SLOTS);
  assign tbl_go   = wr_en && !is_ctrl && in_range && !cmd_valid;
  assign issue_we = wr_en && is_ctrl && (sel == '0) && !word_sel;
  assign mem_we   = wr_en && is_ctrl && (sel == '0) && word_sel;

  iseq_slot_table #(
    .SLOTS(SLOTS), .IDX_W(IDX_W), .CMD_W(CMD_W), .PAR_W(WORD_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .wr_go(tbl_go), .wr_idx(sel),
    .wr_word(word_sel), .wr_data(wr_data), .rd_idx(cur_idx),
    .rd_cmd(rd_cmd), .rd_par(rd_par)
  );

  iseq_ctrl_regs #(.SLOTS(SLOTS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .issue_we(issue_we),
    .issue_cnt_in(wr_data[IDX_W-1:0]), .issue_valid_in(wr_data[VALID_POS]),
    .mem_we(mem_we), .mem_start_in(wr_data[START_POS]),
    .mem_done_in(wr_data[DONE_POS]), .seq_busy(seq_busy), .seq_done(seq_done),
    .cmd_valid(cmd_valid), .init_done(init_done), .launch(launch),
    .last_idx(last_idx)
  );

  iseq_engine #(.IDX_W(IDX_W), .DLY_W(DLY_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .launch(launch), .last_idx(last_idx),
    .slot_dly(rd_par[WORD_W-1:FIELD_W]), .idx(cur_idx),
    .issue_stb(issue_stb), .seq_busy(seq_busy), .seq_done(seq_done),
    .cke_q(cke_q)
  );

  assign {cs_n, ras_n, cas_n, we_n} = issue_stb ? rd_cmd[PIN_W-1:0] : {PIN_W{1'b1}};
  assign ba   = issue_stb ? rd_cmd[PIN_W +: BA_W] : '0;
  assign addr = issue_stb ? compose_addr(rd_cmd, rd_par) : '0;
  assign cke  = cke_q || issue_stb;

endmodule

// File: rtl/iseq_checker.sv
module iseq_checker (
  input logic clk,
  input logic rst_n,
  input logic issue_stb,
  input logic seq_busy,
  input logic seq_done,
  input logic cke,
  input logic cmd_valid
);

  // R2: an issue lasts one cycle
  a_r2_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stb |=> !issue_stb);

  // R8: clock enable is high whenever a command goes out
  a_r8_cke_on_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue_stb |-> cke);

  // R8: once high, clock enable never drops
  a_r8_cke_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R5: the valid flag covers the whole run
  a_r5_valid_during_run: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy |-> cmd_valid);

  // R5: the valid flag drops right after the final pause
  a_r5_valid_clears: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !cmd_valid);

endmodule

bind init_cmd_sequencer iseq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .issue_stb(issue_stb), .seq_busy(seq_busy),
  .seq_done(seq_done), .cke(cke), .cmd_valid(cmd_valid)
);

// File: tb/init_cmd_sequencer_tb.sv
module init_cmd_sequencer_tb;

  localparam int SLOTS = 12;
  localparam int BA_W = 3;
  localparam int ADDR_W = 14;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic cke, cs_n, ras_n, cas_n, we_n, cmd_valid, init_done;
  logic [BA_W-1:0] ba;
  logic [ADDR_W-1:0] addr;

  init_cmd_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .cmd_valid(cmd_valid), .init_done(init_done)
  );

  always #10 clk = ~clk;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [9:0]  m_cmd [SLOTS];
  logic [31:0] m_par [SLOTS];
  bit m_valid, m_run, m_issue, m_cke, m_done;
  int m_slot, m_left, m_last, m_count;

  always @(posedge clk) begin
    bit was_valid, was_run;
    int ix;
    if (!rst_n) begin
      m_valid = 0; m_run = 0; m_issue = 0; m_cke = 0; m_done = 0;
      m_slot = 0; m_left = 0; m_last = 0; m_count = 0;
      for (int i = 0; i < SLOTS; i++) begin m_cmd[i] = '0; m_par[i] = '0; end
    end else begin
      was_valid = m_valid;
      was_run = m_run;
      if (m_run) begin
        if (m_issue) begin
          m_cke = 1;
          m_left = int'(m_par[m_slot][31:11]) + 1;
          m_issue = 0;
        end else begin
          m_left--;
          if (m_left == 0) begin
            if (m_slot == m_last) begin m_run = 0; m_valid = 0; end
            else begin m_slot++; m_issue = 1; end
          end
        end
      end
      if (wr_en) begin
        ix = int'(wr_addr[4:1]);
        if (!wr_addr[5]) begin
          if (!was_valid && ix < SLOTS) begin
            if (wr_addr[0]) m_par[ix] = wr_data;
            else m_cmd[ix] = wr_data[9:0];
          end
        end else if (ix == 0 && !wr_addr[0]) begin
          if (!was_run) begin m_count = int'(wr_data[3:0]); m_valid = wr_data[31]; end
        end else if (ix == 0) begin
          m_done = wr_data[1];
          if (wr_data[0] && was_valid && !was_run) begin
            m_run = 1; m_slot = 0; m_issue = 1;
            m_last = (m_count > SLOTS - 1) ? SLOTS - 1 : m_count;
          end
        end
      end
    end
  end

  // ---------------- per-cycle compare and event log ----------------
  int issue_t[$];
  logic [3:0] issue_pins[$];
  logic [BA_W-1:0] issue_ba[$];
  logic [ADDR_W-1:0] issue_addr[$];
  int fall_t = -1;
  bit prev_valid = 0;

  always @(negedge clk) begin
    logic [20:0] exp_bus, act_bus;
    if (rst_n) begin
      act_bus = {cs_n, ras_n, cas_n, we_n, ba, addr};
      if (m_issue)
        exp_bus = {m_cmd[m_slot][3:0], m_cmd[m_slot][6:4], m_cmd[m_slot][9:7], m_par[m_slot][10:0]};
      else
        exp_bus = {4'hf, 3'b0, 14'b0};
      check(act_bus == exp_bus, m_issue ? "R2 bus" : "R7 bus", act_bus, exp_bus);
      check(cke == (m_cke || m_issue), "R8 cke", cke, m_cke || m_issue);
      check(cmd_valid == m_valid, "R5 valid", cmd_valid, m_valid);
      check(init_done == m_done, "R10 init_done", init_done, m_done);
      if (!cs_n) begin
        issue_t.push_back(cyc);
        issue_pins.push_back({cs_n, ras_n, cas_n, we_n});
        issue_ba.push_back(ba);
        issue_addr.push_back(addr);
      end
      if (prev_valid && !cmd_valid) fall_t = cyc;
      prev_valid = cmd_valid;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(input int i, input logic [3:0] pins, input logic [2:0] b,
                      input logic [2:0] ahi, input logic [10:0] alo, input int stored);
    logic [20:0] sd;
    sd = 21'(stored);
    wr({1'b0, 4'(i), 1'b0}, {22'b0, ahi, b, pins});
    wr({1'b0, 4'(i), 1'b1}, {sd, alo});
  endtask

  task automatic clear_log();
    issue_t.delete(); issue_pins.delete(); issue_ba.delete(); issue_addr.delete();
    fall_t = -1;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (cmd_valid && k < 20000) begin @(negedge clk); k++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input int count);
    wr(6'h20, 32'h8000_0000 | 32'(count));
    clear_log();
    wr(6'h21, 32'h1);
    wait_idle();
  endtask

  task automatic finish_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R5 watchdog actual=%0d expected=<100000", cyc);
      finish_up();
    end
  end

  int sd[SLOTS] = '{20, 3, 1, 1, 1, 1, 3, 6, 6, 0, 1, 2};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check(cmd_valid == 0, "R11 valid", cmd_valid, 0);
    check(init_done == 0, "R11 init_done", init_done, 0);
    check(cke == 0, "R11 cke", cke, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'hf, "R11 bus", {cs_n, ras_n, cas_n, we_n}, 4'hf);

    // Typical power-up list (R1, R2, R3, R4, R5)
    load(0, 4'b0111, 3'd0, 3'd0, 11'h000, sd[0]);
    load(1, 4'b0010, 3'd0, 3'd0, 11'h400, sd[1]);
    load(2, 4'b0000, 3'd2, 3'd0, 11'h000, sd[2]);
    load(3, 4'b0000, 3'd3, 3'd0, 11'h000, sd[3]);
    load(4, 4'b0000, 3'd1, 3'd0, 11'h040, sd[4]);
    load(5, 4'b0000, 3'd0, 3'd0, 11'h153, sd[5]);
    load(6, 4'b0010, 3'd0, 3'd0, 11'h400, sd[6]);
    load(7, 4'b0001, 3'd0, 3'd0, 11'h000, sd[7]);
    load(8, 4'b0001, 3'd0, 3'd0, 11'h000, sd[8]);
    load(9, 4'b0000, 3'd0, 3'd5, 11'h053, sd[9]);
    load(10, 4'b0000, 3'd1, 3'd0, 11'h3c0, sd[10]);
    load(11, 4'b0000, 3'd1, 3'd0, 11'h040, sd[11]);
    check(cke == 0, "R8 cke before first issue", cke, 0);
    run(11);
    check(issue_t.size() == 12, "R4 twelve issues", issue_t.size(), 12);
    if (issue_t.size() == 12) begin
      for (int i = 1; i < 12; i++)
        check(issue_t[i] - issue_t[i-1] == sd[i-1] + 2, "R3 spacing",
              issue_t[i] - issue_t[i-1], sd[i-1] + 2);
      check(fall_t == issue_t[11] + sd[11] + 2, "R5 valid fall", fall_t, issue_t[11] + sd[11] + 2);
      check(issue_addr[1] == 14'h0400, "R1 precharge-all A10", issue_addr[1], 14'h0400);
      check(issue_ba[3] == 3'd3, "R1 bank field", issue_ba[3], 3);
      check(issue_addr[9] == 14'h2853, "R1 high address bits", issue_addr[9], 14'h2853);
      check(issue_pins[7] == 4'b0001, "R1 pin field", issue_pins[7], 4'b0001);
    end
    check(cke == 1, "R8 cke after run", cke, 1);

    // R9: table locked while valid, issue register locked while running
    wr(6'h20, 32'h8000_0000);
    load(0, 4'b0001, 3'd0, 3'd0, 11'h000, 0);
    clear_log();
    wr(6'h21, 32'h1);
    repeat (5) @(negedge clk);
    wr(6'h20, 32'h8000_0005);
    wait_idle();
    check(issue_t.size() == 1, "R9 issue write ignored", issue_t.size(), 1);
    if (issue_t.size() == 1)
      check(issue_pins[0] == 4'b0111, "R9 table write ignored", issue_pins[0], 4'b0111);
    check(cmd_valid == 0, "R9 valid after run", cmd_valid, 0);

    // R6: start while valid clear
    clear_log();
    wr(6'h21, 32'h1);
    repeat (30) @(negedge clk);
    check(issue_t.size() == 0, "R6 start ignored", issue_t.size(), 0);
    check(cmd_valid == 0, "R6 valid stays low", cmd_valid, 0);

    // R4: count above the table size is clamped
    run(15);
    check(issue_t.size() == 12, "R4 clamp", issue_t.size(), 12);

    // R10: init-done bit
    clear_log();
    wr(6'h21, 32'h2);
    check(init_done == 1, "R10 set", init_done, 1);
    repeat (3) @(negedge clk);
    check(issue_t.size() == 0, "R10 no bus activity", issue_t.size(), 0);
    wr(6'h21, 32'h0);
    check(init_done == 0, "R10 clear", init_done, 0);

    // R3: stored zero gives two-cycle spacing
    load(0, 4'b0000, 3'd1, 3'd0, 11'h123, 0);
    load(1, 4'b0000, 3'd2, 3'd0, 11'h124, 0);
    load(2, 4'b0000, 3'd3, 3'd0, 11'h125, 0);
    run(2);
    check(issue_t.size() == 3, "R4 three issues", issue_t.size(), 3);
    if (issue_t.size() == 3) begin
      check(issue_t[1] - issue_t[0] == 2, "R3 zero delay", issue_t[1] - issue_t[0], 2);
      check(issue_t[2] - issue_t[1] == 2, "R3 zero delay", issue_t[2] - issue_t[1], 2);
      check(fall_t - issue_t[2] == 2, "R5 zero delay end", fall_t - issue_t[2], 2);
    end

    // R5: long pause on a single slot
    load(0, 4'b0010, 3'd0, 3'd0, 11'h400, 1000);
    run(0);
    check(issue_t.size() == 1, "R4 single slot", issue_t.size(), 1);
    if (issue_t.size() == 1)
      check(fall_t - issue_t[0] == 1002, "R5 long pause", fall_t - issue_t[0], 1002);
    check(cke == 1, "R8 cke stays high", cke, 1);

    finish_up();
  end

endmodule